// File: doc/BRIEF.md
# Audio Master and Bit Clock Divider

This block turns a requested master-clock rate and a requested bit-clock rate into divider settings for an audio serial port, and then produces the matching clock enables. Two reference clocks are available, 24.576 MHz and 19.2 MHz. Each one arrives as a single-cycle enable on the system clock. For the master clock and for the bit clock separately, the block picks a reference, works out the integer ratio, and validates it. An accepted request stores an encoded master ratio in one of two ratio registers, and stores the bit-clock divisor as ratio minus one.

A request is presented for one cycle on `cfg_valid_i`. One cycle later the block acknowledges it and reports whether it was rejected. A rejected request changes nothing. From then on the block emits a master-clock tick and a bit-clock tick. The tick counters restart at the clock edge that accepts a new configuration, so the phase after a reprogram is known.

The fractional divider that sits behind the 24.576 MHz path runs at a fixed 1/1 ratio. Choosing that reference for the bit clock is reported on `bclk_src_a_o`, which routes that divider output to the bit clock.

Top module: `audio_clk_div`

## Requirements
- R1: A request is rejected when the MCLK rate is 0 or above 24576000, or when the BCLK rate is 0 or above the MCLK rate. `cfg_ack_o` pulses exactly one cycle after `cfg_valid_i`, and `cfg_err_o` is 1 in that cycle for a rejected request.
- R2: The MCLK reference is 24.576 MHz (`mclk_src_a_o`=1) whenever 24576000 is an exact multiple of the rate. Otherwise it is 19.2 MHz (`mclk_src_a_o`=0), but only if the rate is at most 19200000 and divides it exactly. Any other rate is rejected.
- R3: The BCLK reference is chosen by the same rule, independently of the MCLK choice. `bclk_src_a_o`=1 means 24.576 MHz, and 24.576 MHz is preferred when both references divide exactly.
- R4: The MCLK ratio (reference/MCLK) must be 1, 2, 4 or 8. These ratios are stored as the 12-bit codes 0xFFF, 0x000, 0x002 and 0x006. Any other ratio is rejected.
- R5: `bclk_div_o` holds (reference/BCLK)-1. A request whose value exceeds 4095 (the 12-bit field) is rejected.
- R6: The MCLK index must be 0 or 1. Index 0 writes `mclk_code0_o` and index 1 writes `mclk_code1_o`; the other register keeps its value. Index 2 or 3 is rejected.
- R7: A rejected request leaves both ratio codes, both source flags and the divisor unchanged.
- R8: After reset both ratio codes are 0xFFF, the divisor is 0, both source flags are 0, and `cfg_ack_o` and `cfg_err_o` are 0.
- R9: `mclk_tick_o` uses the ratio register named by the last accepted index and the selected MCLK reference enable. For a bypass code it equals that enable in the same cycle. For a ratio r it pulses on every r-th reference enable, counted from the accepting edge.
- R10: `bclk_tick_o` pulses on every (divisor+1)-th enable of the selected BCLK reference, counted from the accepting edge. `bclk_o` is high for the first (divisor+1)/2 enables of each period, which gives 50% duty for even ratios.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_valid_i | input | 1 | One-cycle request strobe |
| mclk_rate_i | input | 25 | Requested MCLK rate in Hz |
| bclk_rate_i | input | 25 | Requested BCLK rate in Hz |
| mclk_idx_i | input | 2 | Ratio register index |
| ref_a_tick_i | input | 1 | 24.576 MHz reference enable |
| ref_b_tick_i | input | 1 | 19.2 MHz reference enable |
| cfg_ack_o | output | 1 | Request handled (one cycle after strobe) |
| cfg_err_o | output | 1 | Request rejected (valid with ack) |
| mclk_code0_o | output | 12 | Encoded ratio register 0 |
| mclk_code1_o | output | 12 | Encoded ratio register 1 |
| mclk_src_a_o | output | 1 | MCLK uses 24.576 MHz |
| bclk_src_a_o | output | 1 | BCLK uses 24.576 MHz via the fractional divider |
| bclk_div_o | output | 12 | Bit-clock divisor minus one |
| mclk_tick_o | output | 1 | Master-clock enable |
| bclk_tick_o | output | 1 | Bit-clock period enable |
| bclk_o | output | 1 | Bit-clock level |

## Verification
Acknowledge, error flag and the stored fields all change at the clock edge after the strobe. The scoreboard therefore compares them at the falling edge that follows that edge, and it does so only when `cfg_ack_o` is high. The tick outputs follow the reference enables in the same cycle. The bench drives the enables at a falling edge and samples 2 ns later, before the next rising edge. Tick counts over fixed windows start right after an accepting edge, because that edge restarts both counters.

// File: rtl/audio_clk_div_pkg.sv
package audio_clk_div_pkg;
  localparam int unsigned CODE_W = 12;
  localparam logic [CODE_W-1:0] CODE_BYPASS = '1;

  typedef struct packed {
    logic              ok;
    logic [CODE_W-1:0] code;
  } ratio_enc_t;

  // sparse MCLK ratio encoding
  function automatic ratio_enc_t enc_ratio(input logic [31:0] ratio);
    ratio_enc_t r;
    r.ok = 1'b1;
    unique case (ratio)
      32'd1:   r.code = CODE_BYPASS;
      32'd2:   r.code = CODE_W'(0);
      32'd4:   r.code = CODE_W'(2);
      32'd8:   r.code = CODE_W'(6);
      default: begin r.ok = 1'b0; r.code = CODE_BYPASS; end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/audio_clk_src_pick.sv
module audio_clk_src_pick #(
  parameter int unsigned RATE_W = 25,
  parameter int unsigned REF_A  = 24576000,
  parameter int unsigned REF_B  = 19200000
) (
  input  logic [RATE_W-1:0] rate_i,
  output logic              ok_o,
  output logic              use_a_o,
  output logic [RATE_W-1:0] quot_o
);
  localparam logic [RATE_W-1:0] RA = RATE_W'(REF_A);
  localparam logic [RATE_W-1:0] RB = RATE_W'(REF_B);

  logic [RATE_W-1:0] den;
  logic div_a, div_b;

  assign den   = (rate_i == '0) ? RATE_W'(1) : rate_i;
  assign div_a = (rate_i != '0) && ((RA % den) == '0);
  assign div_b = (rate_i != '0) && (rate_i <= RB) && ((RB % den) == '0);

  assign use_a_o = div_a;
  assign ok_o    = div_a | div_b;
  assign quot_o  = div_a ? (RA / den) : (RB / den);
endmodule

// File: rtl/audio_clk_cfg.sv
module audio_clk_cfg
  import audio_clk_div_pkg::*;
#(
  parameter int unsigned RATE_W   = 25,
  parameter int unsigned DIV_W    = 12,
  parameter int unsigned IDX_W    = 2,
  parameter int unsigned NUM_MCLK = 2,
  parameter int unsigned REF_A    = 24576000,
  parameter int unsigned REF_B    = 19200000,
  localparam int unsigned SEL_W   = (NUM_MCLK > 1) ? $clog2(NUM_MCLK) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [RATE_W-1:0] mclk_rate_i,
  input  logic [RATE_W-1:0] bclk_rate_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              ack_o,
  output logic              err_o,
  output logic [CODE_W-1:0] codes_o [NUM_MCLK],
  output logic [SEL_W-1:0]  act_idx_o,
  output logic              msrc_a_o,
  output logic              bsrc_a_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              restart_o,
  output logic [DIV_W-1:0]  new_div_o
);
  localparam logic [RATE_W-1:0] RA      = RATE_W'(REF_A);
  localparam logic [RATE_W-1:0] DIV_MAX = RATE_W'((1 << DIV_W) - 1);

  logic              m_ok, m_use_a, b_ok, b_use_a;
  logic [RATE_W-1:0] m_quot, b_quot, div_m1;
  ratio_enc_t        m_enc;
  logic              range_ok, idx_ok, div_ok, accept;

  audio_clk_src_pick #(.RATE_W(RATE_W), .REF_A(REF_A), .REF_B(REF_B)) u_mpick (
    .rate_i(mclk_rate_i), .ok_o(m_ok), .use_a_o(m_use_a), .quot_o(m_quot));

  audio_clk_src_pick #(.RATE_W(RATE_W), .REF_A(REF_A), .REF_B(REF_B)) u_bpick (
    .rate_i(bclk_rate_i), .ok_o(b_ok), .use_a_o(b_use_a), .quot_o(b_quot));

  assign m_enc    = enc_ratio(32'(m_quot));
  assign range_ok = (mclk_rate_i != '0) && (mclk_rate_i <= RA) &&
                    (bclk_rate_i != '0) && (bclk_rate_i <= mclk_rate_i);
  assign idx_ok   = idx_i < IDX_W'(NUM_MCLK);
  assign div_m1   = b_quot - RATE_W'(1);
  assign div_ok   = (b_quot != '0) && (div_m1 <= DIV_MAX);
  assign accept   = range_ok & m_ok & b_ok & m_enc.ok & idx_ok & div_ok;

  assign restart_o = valid_i & accept;
  assign new_div_o = div_m1[DIV_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o     <= 1'b0;
      err_o     <= 1'b0;
      msrc_a_o  <= 1'b0;
      bsrc_a_o  <= 1'b0;
      div_o     <= '0;
      act_idx_o <= '0;
    end else begin
      ack_o <= valid_i;
      err_o <= valid_i & ~accept;
      if (restart_o) begin
        msrc_a_o  <= m_use_a;
        bsrc_a_o  <= b_use_a;
        div_o     <= new_div_o;
        act_idx_o <= idx_i[SEL_W-1:0];
      end
    end
  end

  for (genvar g = 0; g < NUM_MCLK; g++) begin : g_ratio
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               codes_o[g] <= CODE_BYPASS;
      else if (restart_o && idx_i == IDX_W'(g))  codes_o[g] <= m_enc.code;
    end
  end
endmodule

// File: rtl/audio_clk_ticks.sv
module audio_clk_ticks
  import audio_clk_div_pkg::*;
#(
  parameter int unsigned DIV_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_a_tick_i,
  input  logic              ref_b_tick_i,
  input  logic              msrc_a_i,
  input  logic              bsrc_a_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              restart_i,
  input  logic [DIV_W-1:0]  new_div_i,
  output logic              mclk_tick_o,
  output logic              bclk_tick_o,
  output logic              bclk_o
);
  logic             m_ref, b_ref, bypass;
  logic [2:0]       m_cnt, m_term;
  logic [DIV_W-1:0] b_cnt;
  logic [DIV_W:0]   half;

  assign m_ref  = msrc_a_i ? ref_a_tick_i : ref_b_tick_i;
  assign b_ref  = bsrc_a_i ? ref_a_tick_i : ref_b_tick_i;
  assign bypass = (code_i == CODE_BYPASS);
  // codes 0/2/6 give ratio code+2, so terminal count is code+1
  assign m_term = code_i[2:0] + 3'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                m_cnt <= '0;
    else if (restart_i)         m_cnt <= '0;
    else if (m_ref && !bypass)  m_cnt <= (m_cnt == m_term) ? 3'd0 : m_cnt + 3'd1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         b_cnt <= '0;
    else if (restart_i)  b_cnt <= new_div_i;
    else if (b_ref)      b_cnt <= (b_cnt == '0) ? div_i : b_cnt - DIV_W'(1);
  end

  assign mclk_tick_o = m_ref & (bypass | (m_cnt == m_term));
  assign bclk_tick_o = b_ref & (b_cnt == '0);
  assign half        = ({1'b0, div_i} + (DIV_W+1)'(1)) >> 1;
  assign bclk_o      = ({1'b0, b_cnt} >= half);
endmodule

// File: rtl/audio_clk_div.sv
module audio_clk_div
  import audio_clk_div_pkg::*;
#(
  parameter int unsigned RATE_W = 25,
  parameter int unsigned DIV_W  = 12,
  parameter int unsigned IDX_W  = 2,
  parameter int unsigned REF_A  = 24576000,
  parameter int unsigned REF_B  = 19200000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_valid_i,
  input  logic [RATE_W-1:0] mclk_rate_i,
  input  logic [RATE_W-1:0] bclk_rate_i,
  input  logic [IDX_W-1:0]  mclk_idx_i,
  input  logic              ref_a_tick_i,
  input  logic              ref_b_tick_i,
  output logic              cfg_ack_o,
  output logic              cfg_err_o,
  output logic [CODE_W-1:0] mclk_code0_o,
  output logic [CODE_W-1:0] mclk_code1_o,
  output logic              mclk_src_a_o,
  output logic              bclk_src_a_o,
  output logic [DIV_W-1:0]  bclk_div_o,
  output logic              mclk_tick_o,
  output logic              bclk_tick_o,
  output logic              bclk_o
);
  localparam int unsigned NUM_MCLK = 2;
  localparam int unsigned SEL_W    = $clog2(NUM_MCLK);

  logic [CODE_W-1:0] codes [NUM_MCLK];
  logic [SEL_W-1:0]  act_idx;
  logic              restart;
  logic [DIV_W-1:0]  new_div;

  audio_clk_cfg #(
    .RATE_W(RATE_W), .DIV_W(DIV_W), .IDX_W(IDX_W), .NUM_MCLK(NUM_MCLK),
    .REF_A(REF_A), .REF_B(REF_B)
  ) u_cfg (
    .clk_i, .rst_ni,
    .valid_i(cfg_valid_i), .mclk_rate_i, .bclk_rate_i, .idx_i(mclk_idx_i),
    .ack_o(cfg_ack_o), .err_o(cfg_err_o), .codes_o(codes), .act_idx_o(act_idx),
    .msrc_a_o(mclk_src_a_o), .bsrc_a_o(bclk_src_a_o), .div_o(bclk_div_o),
    .restart_o(restart), .new_div_o(new_div)
  );

  audio_clk_ticks #(.DIV_W(DIV_W)) u_ticks (
    .clk_i, .rst_ni, .ref_a_tick_i, .ref_b_tick_i,
    .msrc_a_i(mclk_src_a_o), .bsrc_a_i(bclk_src_a_o),
    .code_i(codes[act_idx]), .div_i(bclk_div_o),
    .restart_i(restart), .new_div_i(new_div),
    .mclk_tick_o, .bclk_tick_o, .bclk_o
  );

  assign mclk_code0_o = codes[0];
  assign mclk_code1_o = codes[1];
endmodule

// File: rtl/audio_clk_div_chk.sv
module audio_clk_div_chk #(
  parameter int unsigned CW = 12,
  parameter int unsigned DW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_valid_i,
  input logic          ref_a_tick_i,
  input logic          ref_b_tick_i,
  input logic          cfg_ack_o,
  input logic          cfg_err_o,
  input logic [CW-1:0] mclk_code0_o,
  input logic [CW-1:0] mclk_code1_o,
  input logic          mclk_src_a_o,
  input logic          bclk_src_a_o,
  input logic [DW-1:0] bclk_div_o,
  input logic          mclk_tick_o,
  input logic          bclk_tick_o
);
  a_r1_ack_follows_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_ack_o |-> $past(cfg_valid_i));

  a_r1_err_only_with_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> cfg_ack_o);

  a_r4_code_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mclk_code0_o == '1) || (mclk_code0_o == CW'(0)) || (mclk_code0_o == CW'(2)) || (mclk_code0_o == CW'(6))) &&
    ((mclk_code1_o == '1) || (mclk_code1_o == CW'(0)) || (mclk_code1_o == CW'(2)) || (mclk_code1_o == CW'(6))));

  a_r6_one_register: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_ack_o && !cfg_err_o) |-> ($stable(mclk_code0_o) || $stable(mclk_code1_o)));

  a_r7_reject_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_ack_o && cfg_err_o) |-> ($stable(mclk_code0_o) && $stable(mclk_code1_o) &&
                                  $stable(bclk_div_o) && $stable(mclk_src_a_o) &&
                                  $stable(bclk_src_a_o)));

  a_r9_mclk_on_ref: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mclk_tick_o |-> (mclk_src_a_o ? ref_a_tick_i : ref_b_tick_i));

  a_r10_bclk_on_ref: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bclk_tick_o |-> (bclk_src_a_o ? ref_a_tick_i : ref_b_tick_i));
endmodule

bind audio_clk_div audio_clk_div_chk u_chk (.*);

// File: tb/audio_clk_div_test.sv
module audio_clk_div_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic [24:0] mclk_rate = '0, bclk_rate = '0;
  logic [1:0]  mclk_idx = '0;
  logic        ref_a = 1'b0, ref_b = 1'b0;
  logic        cfg_ack, cfg_err, msrc_a, bsrc_a, mclk_tick, bclk_tick, bclk;
  logic [11:0] code0, code1, bdiv;

  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  audio_clk_div uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_valid_i(cfg_valid),
    .mclk_rate_i(mclk_rate), .bclk_rate_i(bclk_rate), .mclk_idx_i(mclk_idx),
    .ref_a_tick_i(ref_a), .ref_b_tick_i(ref_b),
    .cfg_ack_o(cfg_ack), .cfg_err_o(cfg_err),
    .mclk_code0_o(code0), .mclk_code1_o(code1),
    .mclk_src_a_o(msrc_a), .bclk_src_a_o(bsrc_a), .bclk_div_o(bdiv),
    .mclk_tick_o(mclk_tick), .bclk_tick_o(bclk_tick), .bclk_o(bclk)
  );

  typedef struct {
    string       tag;
    bit          err;
    logic [11:0] c0, c1, dv;
    bit          ms, bs;
  } exp_t;

  exp_t q[$];
  logic [11:0] sh_c0 = 12'hFFF, sh_c1 = 12'hFFF, sh_dv = 12'h0;
  bit          sh_ms = 0, sh_bs = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // expected result from the requirements
  task automatic model(input longint m, input longint b, input int idx,
                       output bit ok, output logic [11:0] code,
                       output bit ms, output bit bs, output logic [11:0] dv);
    longint A = 24576000, B = 19200000, mq = 0, bq = 0;
    ok = 1; ms = 0; bs = 0; code = 12'hFFF; dv = 0;
    if (m == 0 || m > A || b == 0 || b > m) ok = 0;
    if (ok) begin
      if (A % m == 0) begin ms = 1; mq = A / m; end
      else if (m <= B && B % m == 0) begin ms = 0; mq = B / m; end
      else ok = 0;
    end
    if (ok) begin
      if (A % b == 0) begin bs = 1; bq = A / b; end
      else if (b <= B && B % b == 0) begin bs = 0; bq = B / b; end
      else ok = 0;
    end
    if (ok) begin
      case (mq)
        1: code = 12'hFFF;
        2: code = 12'h000;
        4: code = 12'h002;
        8: code = 12'h006;
        default: ok = 0;
      endcase
      if (bq - 1 > 4095) ok = 0; else dv = 12'(bq - 1);
      if (idx > 1) ok = 0;
    end
  endtask

  // driver: pushes the expected result, then strobes the request
  task automatic apply(input longint m, input longint b, input int idx, input string tag);
    exp_t e;
    bit ok, ms, bs;
    logic [11:0] code, dv;
    model(m, b, idx, ok, code, ms, bs, dv);
    if (ok) begin
      if (idx == 0) sh_c0 = code; else sh_c1 = code;
      sh_ms = ms; sh_bs = bs; sh_dv = dv;
    end
    e.tag = tag; e.err = !ok; e.c0 = sh_c0; e.c1 = sh_c1;
    e.dv = sh_dv; e.ms = sh_ms; e.bs = sh_bs;
    q.push_back(e);
    @(negedge clk);
    mclk_rate = 25'(m); bclk_rate = 25'(b); mclk_idx = 2'(idx); cfg_valid = 1'b1;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  // monitor: compare at the falling edge after the acknowledging edge
  always @(negedge clk) begin
    if (rst_n && cfg_ack) begin
      exp_t e;
      if (q.size() == 0) chk(0, "R1", "unexpected ack", 1, 0);
      else begin
        e = q.pop_front();
        chk(cfg_err == e.err, e.tag, "err", cfg_err, e.err);
        chk(code0 == e.c0, e.tag, "code0", code0, e.c0);
        chk(code1 == e.c1, e.tag, "code1", code1, e.c1);
        chk(bdiv == e.dv, e.tag, "bclk_div", bdiv, e.dv);
        chk(msrc_a == e.ms, e.tag, "mclk_src", msrc_a, e.ms);
        chk(bsrc_a == e.bs, e.tag, "bclk_src", bsrc_a, e.bs);
      end
    end
  end

  task automatic run_ticks(input int n, input int pa, input int pb,
                           output int mt, output int bt, output int hi, output int mis);
    mt = 0; bt = 0; hi = 0; mis = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      ref_a = (k % pa == 0);
      ref_b = (k % pb == 0);
      #2;
      mt += int'(mclk_tick);
      bt += int'(bclk_tick);
      hi += int'(bclk);
      if (mclk_tick !== ref_a) mis++;
    end
    @(negedge clk);
    ref_a = 1'b0; ref_b = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int mt, bt, hi, mis;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(code0 == 12'hFFF && code1 == 12'hFFF, "R8", "reset codes", {code0, code1}, 24'hFFFFFF);
    chk(bdiv == 0 && !msrc_a && !bsrc_a, "R8", "reset div/src", {bdiv, msrc_a, bsrc_a}, 0);
    chk(!cfg_ack && !cfg_err, "R8", "reset ack/err", {cfg_ack, cfg_err}, 0);

    apply(24576000, 3072000, 0, "R4_bypass");
    apply(12288000,  768000, 1, "R3_prefer_a");
    apply( 9600000, 2400000, 0, "R2_ref_b");
    apply( 4800000,   48000, 1, "R4_ratio4");
    apply( 3072000,    6000, 0, "R5_max_div");
    apply( 3072000,    3000, 0, "R5_div_over");
    apply( 1536000,   48000, 0, "R4_ratio16");
    apply(       0,    1000, 0, "R1_mclk_zero");
    apply(24576001,    1000, 0, "R1_mclk_high");
    apply( 3072000,       0, 0, "R1_bclk_zero");
    apply( 3072000, 6144000, 0, "R1_bclk_high");
    apply(11000000, 1000000, 0, "R2_no_ref");
    apply(24576000, 7000000, 0, "R3_no_ref");
    apply(12288000, 1536000, 2, "R6_bad_idx");
    apply(19200000, 4800000, 1, "R6_idx1");
    apply(12288000, 1536000, 0, "R7_after_reject");

    // bypass ratio and bit-clock period, 24.576 MHz on every third cycle
    apply(24576000, 3072000, 0, "R9_setup");
    run_ticks(64, 3, 1, mt, bt, hi, mis);
    chk(mis == 0, "R9", "bypass mismatches", mis, 0);
    chk(bt == 2, "R10", "bclk ticks pa=3", bt, 2);

    apply(24576000, 3072000, 0, "R10_setup");
    run_ticks(64, 1, 1, mt, bt, hi, mis);
    chk(mt == 64, "R9", "bypass ticks", mt, 64);
    chk(bt == 8, "R10", "bclk ticks", bt, 8);
    chk(hi == 32, "R10", "bclk high cycles", hi, 32);

    // ratio 2 from register 1
    apply(12288000, 1536000, 1, "R9_setup_div2");
    run_ticks(64, 1, 1, mt, bt, hi, mis);
    chk(mt == 32, "R9", "mclk ticks ratio 2", mt, 32);
    chk(bt == 4, "R10", "bclk ticks div 15", bt, 4);

    // both clocks from the 19.2 MHz enable
    apply(9600000, 2400000, 0, "R2_setup_ref_b");
    run_ticks(80, 1, 4, mt, bt, hi, mis);
    chk(mt == 10, "R9", "mclk ticks on ref b", mt, 10);
    chk(bt == 2, "R10", "bclk ticks on ref b", bt, 2);

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R1", "pending acks", q.size(), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule